// File: doc/BRIEF.md
# Shared Memory Port Arbiter with Structural Fetch Stall

A five-stage pipeline whose instruction fetch and data access share one memory port needs this block. It decides each cycle who owns the port. A load or a store sitting in the memory stage always wins. When that happens, the fetch that would have issued in the same cycle is lost. The block then raises a hold to the program counter and the fetch/decode register, so the front of the pipeline waits one cycle. Instructions that are already past fetch are not held and keep moving.

The lost fetch slot becomes a bubble. The block tracks it as a vacancy flag, one flag per downstream stage (decode, execute, memory, write-back). The flag moves forward one stage on each clock. Decode reads bit 0 as "treat the held fetch/decode contents as a no-op", and later stages can read their own bits. A cycle with no data access hands the port to the fetch address as a read.

Top module: `mem_port_arb`

## Requirements
- R1: When `mem_rd` or `mem_wr` is high, in the same cycle `port_en` is 1 and `port_addr` equals `mem_addr`.
- R2: `port_we` is 1 exactly when `mem_wr` is high, and `mem_wr` wins over `mem_rd` if both are high. `port_wdata` equals `mem_wdata` during a store and is all zeros otherwise.
- R3: With no data access and `if_req` high, the port serves the fetch in the same cycle: `port_addr` = `if_addr`, `port_en` = 1, `port_we` = 0, `front_hold` = 0.
- R4: With no data access and `if_req` low, `port_en` and `port_we` are 0, and `port_addr` and `port_wdata` are all zeros.
- R5: `front_hold` is high in a cycle exactly when a data access (load or store) and `if_req` are both high in that cycle. A data access with `if_req` low raises no hold.
- R6: A cycle in which `front_hold` is high sets `bubble_at[0]` (decode) high for the next cycle only. A cycle without a hold leaves `bubble_at[0]` low in the next cycle.
- R7: A vacancy moves one stage per clock: a hold in cycle t shows on `bubble_at[k]` in cycle t+1+k and then leaves the vector after the last stage.
- R8: Back-to-back data accesses that each steal a fetch give separate bubbles in consecutive cycles. None of them is merged or dropped.
- R9: While `rst_n` is low, every bit of `bubble_at` is 0, including vacancies that were in flight before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rd | input | 1 | Memory-stage instruction is a load |
| mem_wr | input | 1 | Memory-stage instruction is a store |
| mem_addr | input | ADDR_W | Data access address |
| mem_wdata | input | DATA_W | Store data |
| if_req | input | 1 | Fetch stage wants an instruction this cycle |
| if_addr | input | ADDR_W | Fetch address (program counter) |
| port_addr | output | ADDR_W | Address presented to the shared memory |
| port_en | output | 1 | Memory port access enable |
| port_we | output | 1 | Memory port write enable |
| port_wdata | output | DATA_W | Write data to the shared memory |
| front_hold | output | 1 | Hold for the program counter and the fetch/decode register |
| bubble_at | output | STAGES | Vacancy flags; bit 0 = decode, higher bits = later stages |

## Verification
The port outputs and `front_hold` are combinational, so they are due in the same cycle as the inputs that cause them. Bit k of `bubble_at` is due k+1 clock edges after the cycle that lost its fetch. The driver applies inputs on the falling edge and queues the expected values for that cycle. For the vacancy vector it builds the expected value from its own history of lost fetches, shifted once per driven cycle. The monitor checks one nanosecond after the same falling edge, so every result is read after the rising edge that should have produced it and before the next inputs arrive.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

    typedef enum logic [1:0] {
        OWN_IDLE  = 2'd0,
        OWN_FETCH = 2'd1,
        OWN_LOAD  = 2'd2,
        OWN_STORE = 2'd3
    } port_owner_e;

    function automatic logic owner_is_data(input port_owner_e o);
        return (o == OWN_LOAD) || (o == OWN_STORE);
    endfunction

endpackage

// File: rtl/mpa_port_mux.sv
module mpa_port_mux
    import mpa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    input  logic              if_req,
    input  logic [ADDR_W-1:0] if_addr,
    output port_owner_e       owner,
    output logic [ADDR_W-1:0] port_addr,
    output logic [DATA_W-1:0] port_wdata,
    output logic              port_en,
    output logic              port_we
);

    // Ownership: store beats load, any data access beats fetch.
    always_comb begin
        if (mem_wr)       owner = OWN_STORE;
        else if (mem_rd)  owner = OWN_LOAD;
        else if (if_req)  owner = OWN_FETCH;
        else              owner = OWN_IDLE;
    end

    always_comb begin
        port_addr  = '0;
        port_wdata = '0;
        port_en    = 1'b0;
        port_we    = 1'b0;
        unique case (owner)
            OWN_STORE: begin
                port_addr  = mem_addr;
                port_wdata = mem_wdata;
                port_en    = 1'b1;
                port_we    = 1'b1;
            end
            OWN_LOAD: begin
                port_addr = mem_addr;
                port_en   = 1'b1;
            end
            OWN_FETCH: begin
                port_addr = if_addr;
                port_en   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mpa_slot_tracker.sv
module mpa_slot_tracker #(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inject,
    output logic [STAGES-1:0] vacant
);

    typedef struct packed {
        logic [STAGES-1:0] slot;
    } trk_state_t;

    trk_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.slot[0] = inject;
        for (int i = 1; i < STAGES; i++) begin
            st_d.slot[i] = st_q.slot[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vacant = st_q.slot;

    // R6
    head_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inject |=> vacant[0]);

    // R6
    head_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inject |=> !vacant[0]);

    for (genvar g = 1; g < STAGES; g++) begin : g_stage_chk
        // R7
        slot_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
            vacant[g-1] |=> vacant[g]);

        // R7
        slot_no_spawn_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !vacant[g-1] |=> !vacant[g]);
    end

endmodule

// File: rtl/mem_port_arb.sv
module mem_port_arb
    import mpa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    input  logic              if_req,
    input  logic [ADDR_W-1:0] if_addr,
    output logic [ADDR_W-1:0] port_addr,
    output logic              port_en,
    output logic              port_we,
    output logic [DATA_W-1:0] port_wdata,
    output logic              front_hold,
    output logic [STAGES-1:0] bubble_at
);

    port_owner_e owner;
    logic        fetch_lost;

    mpa_port_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mux (
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .if_req     (if_req),
        .if_addr    (if_addr),
        .owner      (owner),
        .port_addr  (port_addr),
        .port_wdata (port_wdata),
        .port_en    (port_en),
        .port_we    (port_we)
    );

    // A fetch is lost only when one was wanted and the data side owns the port.
    always_comb fetch_lost = owner_is_data(owner) && if_req;

    assign front_hold = fetch_lost;

    mpa_slot_tracker #(
        .STAGES (STAGES)
    ) u_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .inject (fetch_lost),
        .vacant (bubble_at)
    );

    // R1
    data_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (port_en && port_addr == mem_addr));

    // R2
    store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (port_we && port_wdata == mem_wdata));

    // R2
    load_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr |-> (!port_we && port_wdata == '0));

    // R3
    fetch_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd && !mem_wr && if_req) |->
            (port_en && !port_we && port_addr == if_addr && !front_hold));

    // R4
    idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd && !mem_wr && !if_req) |-> (!port_en && !port_we));

    // R5
    hold_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        front_hold |-> ((mem_rd || mem_wr) && if_req && port_addr == mem_addr));

    // R6
    hold_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        front_hold |=> bubble_at[0]);

endmodule

// File: tb/mem_port_arb_tb.sv
module mem_port_arb_tb;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_rd = 1'b0, mem_wr = 1'b0, if_req = 1'b0;
    logic [AW-1:0] mem_addr = '0, if_addr = '0;
    logic [DW-1:0] mem_wdata = '0;
    logic [AW-1:0] port_addr;
    logic          port_en, port_we, front_hold;
    logic [DW-1:0] port_wdata;
    logic [NS-1:0] bubble_at;

    always #2.5 clk = ~clk;

    mem_port_arb #(.ADDR_W(AW), .DATA_W(DW), .STAGES(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .if_req(if_req),
        .if_addr(if_addr), .port_addr(port_addr), .port_en(port_en),
        .port_we(port_we), .port_wdata(port_wdata), .front_hold(front_hold),
        .bubble_at(bubble_at)
    );

    typedef struct {
        logic [AW-1:0] addr;
        logic          en;
        logic          we;
        logic [DW-1:0] wdata;
        logic          hold;
        logic [NS-1:0] bub;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    logic [NS-1:0] lost_hist = '0;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues what the ports must show.
    task automatic step(input logic rd, input logic wr, input logic [AW-1:0] ma,
                        input logic [DW-1:0] wd, input logic rq,
                        input logic [AW-1:0] ia, input string tag);
        exp_t e;
        logic data;
        @(negedge clk);
        mem_rd = rd; mem_wr = wr; mem_addr = ma; mem_wdata = wd;
        if_req = rq; if_addr = ia;
        data    = rd | wr;
        e.en    = data | rq;
        e.we    = wr;
        e.addr  = data ? ma : (rq ? ia : '0);
        e.wdata = wr ? wd : '0;
        e.hold  = data & rq;
        e.bub   = lost_hist;
        e.tag   = tag;
        sb.push_back(e);
        lost_hist = {lost_hist[NS-2:0], e.hold};
    endtask

    // Monitor: compares outputs after the driven edge settles.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(port_en == e.en, e.en && (mem_rd || mem_wr) ? "R1" : (e.en ? "R3" : "R4"),
                    {e.tag, " port_en"}, 64'(port_en), 64'(e.en));
                chk(port_addr == e.addr, (mem_rd || mem_wr) ? "R1" : (if_req ? "R3" : "R4"),
                    {e.tag, " port_addr"}, 64'(port_addr), 64'(e.addr));
                chk(port_we == e.we, "R2", {e.tag, " port_we"}, 64'(port_we), 64'(e.we));
                chk(port_wdata == e.wdata, "R2", {e.tag, " port_wdata"},
                    64'(port_wdata), 64'(e.wdata));
                chk(front_hold == e.hold, "R5", {e.tag, " front_hold"},
                    64'(front_hold), 64'(e.hold));
                chk(bubble_at[0] == e.bub[0], "R6", {e.tag, " bubble_at[0]"},
                    64'(bubble_at[0]), 64'(e.bub[0]));
                chk(bubble_at[NS-1:1] == e.bub[NS-1:1], "R7", {e.tag, " bubble_at upper"},
                    64'(bubble_at[NS-1:1]), 64'(e.bub[NS-1:1]));
            end
        end
    end

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        mem_rd = 1'b0; mem_wr = 1'b0; if_req = 1'b0;
        mem_addr = '0; mem_wdata = '0; if_addr = '0;
        @(posedge clk);
        #1;
        // R9: no vacancy survives reset; idle port
        chk(bubble_at == '0, "R9", {tag, " bubble_at"}, 64'(bubble_at), 64'h0);
        chk(port_en == 1'b0, "R9", {tag, " port_en"}, 64'(port_en), 64'h0);
        lost_hist = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset("init");

        // R3: plain fetch stream, several addresses
        step(0, 0, 32'h0, 32'h0, 1, 32'h0000_1000, "fetch0");
        step(0, 0, 32'h0, 32'h0, 1, 32'h0000_1004, "fetch1");
        step(0, 0, 32'hDEAD, 32'hBEEF, 1, 32'hFFFF_FFFC, "fetch2");
        // R4: idle port
        step(0, 0, 32'h1234, 32'h5678, 0, 32'hAAAA, "idle");

        // R1 R5 R6 R7: load steals the fetch slot, vacancy walks down
        step(0, 0, 32'h0, 32'h0, 1, 32'h0000_2000, "pre");
        step(1, 0, 32'h0000_8000, 32'h0, 1, 32'h0000_2004, "load_steal");
        step(0, 0, 32'h0, 32'h0, 1, 32'h0000_2004, "refetch");
        for (int i = 0; i < NS + 1; i++)
            step(0, 0, 32'h0, 32'h0, 1, 32'h0000_2008 + 4 * i, "drain");

        // R2: store steals fetch with write data
        step(0, 1, 32'h0000_9000, 32'hCAFE_F00D, 1, 32'h0000_3000, "store_steal");
        step(0, 0, 32'h0, 32'h0, 1, 32'h0000_3000, "after_store");

        // R5: data access without fetch request raises no hold, no vacancy
        step(1, 0, 32'h0000_A000, 32'h0, 0, 32'h0, "load_nofetch");
        step(0, 0, 32'h0, 32'h0, 1, 32'h0000_3004, "post_nofetch");

        // R8: back-to-back data accesses give consecutive bubbles
        step(1, 0, 32'h0000_B000, 32'h0, 1, 32'h0000_4000, "b2b_load");
        step(0, 1, 32'h0000_B004, 32'h1111_2222, 1, 32'h0000_4000, "b2b_store");
        step(1, 0, 32'h0000_B008, 32'h0, 1, 32'h0000_4000, "b2b_load2");
        for (int i = 0; i < NS + 1; i++)
            step(0, 0, 32'h0, 32'h0, 1, 32'h0000_4000 + 4 * i, "b2b_drain");

        // R2: store wins over load when both flags are high
        step(1, 1, 32'h0000_C000, 32'h3333_4444, 1, 32'h0000_5000, "rd_wr_both");

        // R9: in-flight vacancies are cleared by reset
        step(1, 0, 32'h0000_D000, 32'h0, 1, 32'h0000_6000, "pre_reset");
        step(0, 0, 32'h0, 32'h0, 1, 32'h0000_6000, "pre_reset2");
        @(negedge clk);
        #2;
        do_reset("mid_reset");
        step(0, 0, 32'h0, 32'h0, 1, 32'h0000_7000, "after_reset");
        step(0, 0, 32'h0, 32'h0, 0, 32'h0, "tail");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule